// File: doc/BRIEF.md
# Receive Character Queue with Error Tags

This block sits between a serial receiver and the register read path. Each character that the receiver finishes arrives here with three error tags: break, parity and framing. The block stores the character and its tags together as one 11-bit entry and hands the entries to the reader in arrival order. A separate sticky overrun flag records that a finished character was lost because there was no room for it. The overrun flag belongs to the queue as a whole and is not tied to any stored entry.

A mode input selects the queue behaviour. With the queue enabled, up to sixteen entries are buffered. With the queue disabled, the same storage acts as a single-character holding register. Only the bottom slot is used, and the full and empty flags report a capacity of one. Changing the mode empties the queue.

The read data is registered. A read updates `rd_word` at the clock edge that removes the entry. A read from an empty queue leaves `rd_word` holding the last value it returned.

Top module: `rxq_top`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `overrun` is 0 and `rd_word` is 0.
- R2: An entry is packed as [10] break tag, [9] parity tag, [8] framing tag, [7:0] character. A read returns the four fields exactly as they were written.
- R3: With `q_en`=1, the queue accepts 16 entries. `full` rises in the cycle after the 16th write is accepted.
- R4: When `rd_en` is 1 and the queue is not empty, the oldest entry is removed at the clock edge and appears on `rd_word` right after that edge. Entries leave in the order they arrived.
- R5: A write presented while `full` is 1 is discarded, even if a read happens in the same cycle. `overrun` is 1 from the next cycle, and the stored entries are unchanged.
- R6: `overrun` stays 1 until `ovr_clr` is pulsed. If a clear and a new overrun happen in the same cycle, the overrun wins.
- R7: With `q_en`=0, the capacity is one entry. `full` is 1 once a character is held. A second character that arrives before the first is read sets `overrun` and leaves the held character in place.
- R8: A read while `empty` is 1 leaves `rd_word`, `empty` and `full` unchanged.
- R9: In a cycle where `q_en` differs from the mode latched at the previous edge, all entries are dropped and that cycle's write and read are ignored. `empty` is 1 afterwards, and `overrun` is not affected. After reset the latched mode is 0.
- R10: A write and a read in the same cycle, with the queue neither empty nor full, both take effect and leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en | input | 1 | 1: 16-entry queue, 0: single holding register |
| wr_valid | input | 1 | A finished character is presented this cycle |
| wr_char | input | 8 | Received character |
| wr_brk | input | 1 | Break tag |
| wr_par | input | 1 | Parity tag |
| wr_frm | input | 1 | Framing tag |
| rd_en | input | 1 | Remove the oldest entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_word | output | 11 | Last entry read: {brk, par, frm, char} |
| empty | output | 1 | No entries held |
| full | output | 1 | Capacity of the current mode reached |
| overrun | output | 1 | Sticky flag: a character was lost |

## Verification
A wrong fill count would show up on `full` or `empty` one cycle after the write or read that caused it. It would also show up as a missing or extra entry by the time the queue is drained. A wrong read pointer would put an out-of-order or mis-tagged word on `rd_word` right after the edge of the read. An overrun flag that is set too early, set too late, or not sticky would be seen in the cycle after the 17th write in queue mode, or after the second write in holding mode. A flush that leaks entries would show as `empty` still low one cycle after the mode changes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] char_v;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rxq_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output rxq_entry_t    rdata
);
  rxq_entry_t slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          wr_valid,
  input  logic          rd_en,
  input  logic          ovr_clr,
  output logic          we,
  output logic          re,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          mode_q,
  output logic [CW-1:0] fill
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          flush;
  logic [CW-1:0] cap;
  logic [AW-1:0] wptr_n, rptr_n;
  logic [CW-1:0] fill_n;
  logic          ovr_n;
  logic          lost;

  assign flush = (q_en != mode_q);
  assign cap   = mode_q ? CW'(DEPTH) : CW'(1);
  assign empty = (fill == '0);
  assign full  = (fill == cap);
  assign we    = wr_valid && !full && !flush;
  assign re    = rd_en && !empty && !flush;
  assign lost  = wr_valid && full && !flush;

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    fill_n = fill;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      fill_n = '0;
    end else begin
      if (we && mode_q) wptr_n = (wptr == LAST) ? '0 : wptr + AW'(1);
      if (re && mode_q) rptr_n = (rptr == LAST) ? '0 : rptr + AW'(1);
      case ({we, re})
        2'b10:   fill_n = fill + CW'(1);
        2'b01:   fill_n = fill - CW'(1);
        default: fill_n = fill;
      endcase
    end
  end

  always_comb begin
    ovr_n = overrun;
    if (ovr_clr) ovr_n = 1'b0;
    if (lost)    ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      fill    <= '0;
      overrun <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      wptr    <= wptr_n;
      rptr    <= rptr_n;
      fill    <= fill_n;
      overrun <= ovr_n;
      mode_q  <= q_en;
    end
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_en,
  input  logic               wr_valid,
  input  logic [CHAR_W-1:0]  wr_char,
  input  logic               wr_brk,
  input  logic               wr_par,
  input  logic               wr_frm,
  input  logic               rd_en,
  input  logic               ovr_clr,
  output logic [ENTRY_W-1:0] rd_word,
  output logic               empty,
  output logic               full,
  output logic               overrun
);
  logic          we, re, mode_q;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;
  rxq_entry_t    wdata, rdata;
  logic [ENTRY_W-1:0] rd_q, rd_n;

  assign wdata = '{brk: wr_brk, par: wr_par, frm: wr_frm, char_v: wr_char};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .wr_valid(wr_valid),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .we(we), .re(re),
    .wptr(wptr), .rptr(rptr), .empty(empty), .full(full),
    .overrun(overrun), .mode_q(mode_q), .fill(fill)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(wptr), .wdata(wdata),
    .raddr(rptr), .rdata(rdata)
  );

  always_comb begin
    rd_n = rd_q;
    if (re) rd_n = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_n;
  end

  assign rd_word = rd_q;
endmodule

// File: rtl/rxq_top_chk.sv
module rxq_top_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          q_en,
  input logic          wr_valid,
  input logic          rd_en,
  input logic          ovr_clr,
  input logic [10:0]   rd_word,
  input logic          empty,
  input logic          full,
  input logic          overrun,
  input logic          mode_q,
  input logic [CW-1:0] fill
);
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_queue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_lost_sets_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && (q_en == mode_q)) |=> overrun);

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(wr_valid && full && (q_en == mode_q))) |=> !overrun);

  assert_single_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !empty) |-> full);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_valid) |=> ($stable(rd_word) && empty));

  assert_mode_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en != mode_q) |=> empty);
endmodule

bind rxq_top rxq_top_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_en(q_en), .wr_valid(wr_valid),
  .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_word(rd_word), .empty(empty),
  .full(full), .overrun(overrun), .mode_q(mode_q), .fill(fill)
);

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_en = 1'b1, wr_valid = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic wr_brk = 1'b0, wr_par = 1'b0, wr_frm = 1'b0;
  logic [7:0]  wr_char = '0;
  logic [10:0] rd_word;
  logic empty, full, overrun;

  int n_chk = 0, n_bad = 0;
  logic [10:0] exp_q[$];
  logic [10:0] chk_q[$];
  int mcnt = 0, mcap = 16;
  logic [10:0] last;

  always #10 clk = ~clk;

  rxq_top u0 (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .wr_valid(wr_valid),
    .wr_char(wr_char), .wr_brk(wr_brk), .wr_par(wr_par), .wr_frm(wr_frm),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_word(rd_word), .empty(empty),
    .full(full), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each granted read after the edge that performs it
  always @(posedge clk) begin
    #2;
    if (chk_q.size() > 0) begin
      logic [10:0] e;
      e = chk_q.pop_front();
      check(rd_word === e, "R2/R4 read word", rd_word, e);
      last = e;
    end
  end

  // driver: one cycle, optional write and read
  task automatic xfer(input bit w, input logic [10:0] word, input bit r);
    @(negedge clk);
    wr_valid = w; rd_en = r;
    {wr_brk, wr_par, wr_frm, wr_char} = word;
    if (r && mcnt > 0) begin
      chk_q.push_back(exp_q.pop_front());
    end
    if (w && (mcnt < mcap)) exp_q.push_back(word);
    mcnt = mcnt + ((w && mcnt < mcap) ? 1 : 0) - ((r && mcnt > 0) ? 1 : 0);
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    q_en = m;
    wr_valid = 1'b1; {wr_brk, wr_par, wr_frm, wr_char} = 11'h3AA; // dropped in flush cycle
    exp_q.delete(); mcnt = 0; mcap = m ? 16 : 1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic flags(input string req, input bit e, input bit f, input bit o);
    check({empty, full, overrun} === {e, f, o}, req, {8'd0, empty, full, overrun}, {8'd0, e, f, o});
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #25;
    flags("R1 reset flags", 1, 0, 0);
    check(rd_word === 11'd0, "R1 reset word", rd_word, 11'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk); // first cycle flushes: latched mode starts at 0
    flags("R9 initial mode latch", 1, 0, 0);

    // R3 fill to 16 with varied tags
    for (int i = 0; i < 16; i++) xfer(1, {i[2:0], 8'(8'h40 + i*7)}, 0);
    flags("R3 full after 16", 0, 1, 0);
    // R5 17th write lost, sets overrun
    xfer(1, 11'h7FF, 0);
    flags("R5 overrun on full write", 0, 1, 1);
    // R5 write while full with simultaneous read: write still lost
    xfer(1, 11'h555, 1);
    check(full === 1'b0, "R5 read frees, write dropped", {10'd0, full}, 11'd0);
    for (int i = 0; i < 15; i++) xfer(0, 11'd0, 1);
    @(negedge clk);
    flags("R4 drained", 1, 0, 1);

    // R8 empty read leaves word
    xfer(0, 11'd0, 1);
    check(rd_word === last, "R8 empty read word", rd_word, last);
    flags("R8 empty read flags", 1, 0, 1);

    // R6 sticky then clear
    repeat (3) @(negedge clk);
    flags("R6 sticky", 1, 0, 1);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    flags("R6 cleared", 1, 0, 0);

    // R10 simultaneous write and read
    xfer(1, 11'h101, 0);
    xfer(1, 11'h202, 0);
    xfer(1, 11'h404, 1);
    flags("R10 level kept", 0, 0, 0);
    xfer(0, 11'd0, 1);
    xfer(0, 11'd0, 1);
    flags("R10 drained", 1, 0, 0);

    // R6 set wins over clear: fill then overflow with clear
    for (int i = 0; i < 16; i++) xfer(1, 11'(i), 0);
    @(negedge clk); wr_valid = 1'b1; ovr_clr = 1'b1;
    @(negedge clk); wr_valid = 1'b0; ovr_clr = 1'b0;
    flags("R6 set beats clear", 0, 1, 1);

    // R9 mode change flushes, overrun untouched, write dropped
    set_mode(1'b0);
    flags("R9 flush", 1, 0, 1);
    @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;

    // R7 holding register
    xfer(1, 11'h4C3, 0);
    flags("R7 full at one", 0, 1, 0);
    xfer(1, 11'h1EE, 0);
    flags("R7 overrun", 0, 1, 1);
    xfer(0, 11'd0, 1);
    flags("R7 emptied", 1, 0, 1);
    xfer(1, 11'h2B1, 0);
    xfer(0, 11'd0, 1);
    flags("R7 reuse", 1, 0, 1);

    // back to queue mode
    set_mode(1'b1);
    flags("R9 flush back", 1, 0, 1);
    xfer(1, 11'h0F0, 0);
    xfer(0, 11'd0, 1);
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule